// File: doc/BRIEF.md
# Integer Decode and Execute Unit

This block accepts one raw 32-bit instruction word per clock and decodes it. The word belongs to a small load/store integer instruction set. The block reads two operands from an internal bank of 32 general registers, 32 bits each, and computes the result combinationally within the same cycle. On the next rising clock edge it commits that result to the destination register. A sequencer around the block presents a word together with a valid strobe. It can watch the result and the destination index that are about to be written, and an illegal-instruction flag.

Two layouts are understood. The register form names two sources, a destination and a shift amount, and selects its operation through a function field. The immediate form names one source and a target, and carries a 16-bit constant. Depending on the operation, that constant is sign-extended, zero-extended or placed in the upper half of the word. Register 0 is hardwired to zero. Memory access and control flow are handled elsewhere.

Top module: `intExecUnit`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, every register is cleared, so afterwards each register reads as zero.
- R2: With opcode [31:26] = 0, the fields are first source [25:21], second source [20:16], destination [15:11], shift amount [10:6] and function [5:0]. Function 32 (add) outputs the sum of the two sources on `result` and the destination on `wbIndex`.
- R3: Register-form function 34 subtracts the second source from the first. Function 36 is bitwise AND, 37 is bitwise OR, and 39 is the bitwise inverse of the OR.
- R4: Function 42 gives 1 when the first source is less than the second as signed two's complement numbers, and 0 otherwise. Opcode 10 does the same comparison against the sign-extended immediate.
- R5: Function 0 shifts the second source left by the shift-amount field and fills with zeros.
- R6: The immediate form uses opcode [31:26], source [25:21], target [20:16] and immediate [15:0], and writes to the target. Opcode 8 adds the sign-extended immediate to the source.
- R7: Opcode 12 (AND) and opcode 13 (OR) combine the source with the immediate after zero-extending it.
- R8: Opcode 15 gives the immediate in bits [31:16] and zeros in bits [15:0].
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: Any other opcode, or any other function under opcode 0, raises `illegal`, forces `result` and `wbIndex` to 0 and writes no register.
- R11: While `instValid` is low, `result`, `wbIndex` and `illegal` are 0 and no register is written.
- R12: `result` and `wbIndex` reflect the present word in the same cycle. The write takes place on the rising edge, so an instruction in the next cycle reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes occur on the rising edge |
| rstN | input | 1 | Active-low synchronous reset, clears the register bank |
| instValid | input | 1 | The instruction word is to be executed this cycle |
| instWord | input | 32 | Raw encoded instruction |
| result | output | 32 | Value to be written back this cycle |
| wbIndex | output | 5 | Register index receiving `result` |
| illegal | output | 1 | Valid word with an unknown opcode or function code |

## Verification
Operands are first built with immediate instructions that give a positive value, a negative value and a value with the top bit set. This separates sign extension from zero extension, and signed from unsigned comparison. Every register is read back after reset, and a write to register 0 is followed by reads of it, which shows whether the zero register is truly hardwired. Back-to-back dependent instructions tell edge-timed commit apart from same-cycle forwarding or late writes. Illegal and non-valid words are each followed by a read of the register they named, to confirm that nothing was written.

// File: rtl/intExecPkg.sv
package intExecPkg;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_LUI
  } aluOpT;

  // strobes from control to datapath
  typedef struct packed {
    aluOpT aluOp;
    logic  useImm;
    logic  immZeroExt;
    logic  destIsRt;
    logic  writeEn;
    logic  illegal;
  } ctrlT;

endpackage

// File: rtl/intDecodeCtrl.sv
module intDecodeCtrl
  import intExecPkg::*;
(
  input  logic       instValid,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctrl
);

  logic  known;
  aluOpT op;
  logic  useImm;
  logic  zeroExt;
  logic  destRt;

  always_comb begin
    known   = 1'b1;
    op      = ALU_ADD;
    useImm  = 1'b0;
    zeroExt = 1'b0;
    destRt  = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_ADD:  op = ALU_ADD;
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_NOR:  op = ALU_NOR;
          FN_SLT:  op = ALU_SLT;
          FN_SLL:  op = ALU_SLL;
          default: known = 1'b0;
        endcase
      end
      OPC_ADDI: begin op = ALU_ADD; useImm = 1'b1; destRt = 1'b1; end
      OPC_SLTI: begin op = ALU_SLT; useImm = 1'b1; destRt = 1'b1; end
      OPC_ANDI: begin op = ALU_AND; useImm = 1'b1; zeroExt = 1'b1; destRt = 1'b1; end
      OPC_ORI:  begin op = ALU_OR;  useImm = 1'b1; zeroExt = 1'b1; destRt = 1'b1; end
      OPC_LUI:  begin op = ALU_LUI; useImm = 1'b1; destRt = 1'b1; end
      default:  known = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.aluOp      = op;
    ctrl.useImm     = useImm;
    ctrl.immZeroExt = zeroExt;
    ctrl.destIsRt   = destRt;
    ctrl.writeEn    = instValid & known;
    ctrl.illegal    = instValid & ~known;
  end

endmodule

// File: rtl/intRegFile.sv
module intRegFile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : mem[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : mem[rdAddrB];

  // R12
  writeLands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=> (mem[$past(wrAddr)] == $past(wrData)));

  // R9
  zeroIgnored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0) |=> (mem[0] == '0));

endmodule

// File: rtl/intAlu.sv
module intAlu
  import intExecPkg::*;
#(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  aluOpT             op,
  input  logic [XLEN-1:0]   opA,
  input  logic [XLEN-1:0]   opB,
  input  logic [SH_W-1:0]   shamt,
  input  logic [HALF-1:0]   imm,
  output logic [XLEN-1:0]   aluOut
);

  always_comb begin
    unique case (op)
      ALU_ADD: aluOut = opA + opB;
      ALU_SUB: aluOut = opA - opB;
      ALU_AND: aluOut = opA & opB;
      ALU_OR:  aluOut = opA | opB;
      ALU_NOR: aluOut = ~(opA | opB);
      ALU_SLT: aluOut = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_SLL: aluOut = opB << shamt;
      ALU_LUI: aluOut = {imm, {HALF{1'b0}}};
      default: aluOut = '0;
    endcase
  end

endmodule

// File: rtl/intDatapath.sv
module intDatapath
  import intExecPkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W = $clog2(REG_COUNT),
  localparam int SH_W  = $clog2(XLEN),
  localparam int HALF  = XLEN / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      instWord,
  input  ctrlT             ctrl,
  output logic [XLEN-1:0]  result,
  output logic [IDX_W-1:0] wbIndex
);

  logic [IDX_W-1:0] rsIdx, rtIdx, rdIdx, destIdx;
  logic [SH_W-1:0]  shamt;
  logic [HALF-1:0]  imm;
  logic [XLEN-1:0]  rsData, rtData, immExt, opB, aluOut;

  assign rsIdx = instWord[25:21];
  assign rtIdx = instWord[20:16];
  assign rdIdx = instWord[15:11];
  assign shamt = instWord[10:6];
  assign imm   = instWord[15:0];

  assign immExt  = ctrl.immZeroExt ? {{(XLEN-HALF){1'b0}}, imm}
                                   : {{(XLEN-HALF){imm[HALF-1]}}, imm};
  assign opB     = ctrl.useImm ? immExt : rtData;
  assign destIdx = ctrl.destIsRt ? rtIdx : rdIdx;

  intRegFile #(.DATA_W(XLEN), .DEPTH(REG_COUNT)) i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .wrEn    (ctrl.writeEn),
    .wrAddr  (destIdx),
    .wrData  (aluOut)
  );

  intAlu #(.XLEN(XLEN)) i_alu (
    .op     (ctrl.aluOp),
    .opA    (rsData),
    .opB    (opB),
    .shamt  (shamt),
    .imm    (imm),
    .aluOut (aluOut)
  );

  assign result  = ctrl.writeEn ? aluOut : '0;
  assign wbIndex = ctrl.writeEn ? destIdx : '0;

  // R8
  luiLowZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeEn && ctrl.aluOp == ALU_LUI) |-> (result[HALF-1:0] == '0));

  // R4
  sltBool_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeEn && ctrl.aluOp == ALU_SLT) |-> (result[XLEN-1:1] == '0));

  // R5
  sllZeroShift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeEn && ctrl.aluOp == ALU_SLL && shamt == '0) |-> (result == rtData));

  // R10
  illegalQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.illegal |-> (result == '0 && wbIndex == '0));

endmodule

// File: rtl/intExecUnit.sv
module intExecUnit
  import intExecPkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [31:0]      instWord,
  output logic [XLEN-1:0]  result,
  output logic [IDX_W-1:0] wbIndex,
  output logic             illegal
);

  ctrlT ctrl;

  intDecodeCtrl i_ctrl (
    .instValid (instValid),
    .opcode    (instWord[31:26]),
    .funct     (instWord[5:0]),
    .ctrl      (ctrl)
  );

  intDatapath #(.XLEN(XLEN), .REG_COUNT(REG_COUNT)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .instWord (instWord),
    .ctrl     (ctrl),
    .result   (result),
    .wbIndex  (wbIndex)
  );

  assign illegal = ctrl.illegal;

  // R11
  idleQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!illegal && result == '0 && wbIndex == '0));

endmodule

// File: tb/test_intExecUnit.sv
module test_intExecUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] result;
  logic [4:0]  wbIndex;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  idx;
    logic        ill;
    string       tag;
  } expT;

  expT sb[$];

  always #10 clk = ~clk;

  intExecUnit i_intExecUnit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .result(result), .wbIndex(wbIndex), .illegal(illegal)
  );

  function automatic logic [31:0] rEnc(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] iEnc(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic exec(input logic v, input logic [31:0] w, input logic [31:0] er,
                      input logic [4:0] ei, input logic eill, input string tag);
    expT e;
    @(negedge clk);
    instValid = v;
    instWord  = w;
    e.res = er; e.idx = ei; e.ill = eill; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare a quarter period after the driver changes inputs
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        expT e;
        e = sb.pop_front();
        checks++;
        if (result !== e.res || wbIndex !== e.idx || illegal !== e.ill) begin
          fails++;
          $display("FAIL %s: result=%h idx=%0d ill=%b expected result=%h idx=%0d ill=%b",
                   e.tag, result, wbIndex, illegal, e.res, e.idx, e.ill);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 1; i < 32; i++)
      exec(1, rEnc(37, i, 0, 1, 0), 32'h0, 5'd1, 0, "R1 reg cleared");

    exec(1, iEnc(8, 0, 1, 5), 32'd5, 5'd1, 0, "R6 addi positive");
    exec(1, iEnc(8, 0, 2, 16'hFFFD), 32'hFFFFFFFD, 5'd2, 0, "R6 addi sign-extend");
    exec(1, rEnc(32, 1, 2, 3, 0), 32'd2, 5'd3, 0, "R2 add");
    exec(1, rEnc(34, 1, 2, 4, 0), 32'd8, 5'd4, 0, "R3 sub");
    exec(1, iEnc(15, 0, 5, 16'h3C00), 32'h3C000000, 5'd5, 0, "R8 lui");
    exec(1, iEnc(13, 5, 5, 16'h8001), 32'h3C008001, 5'd5, 0, "R7 ori zero-extend");
    exec(1, iEnc(12, 2, 6, 16'h8F0F), 32'h00008F0D, 5'd6, 0, "R7 andi zero-extend");
    exec(1, rEnc(36, 5, 6, 7, 0), 32'h00008001, 5'd7, 0, "R3 and");
    exec(1, rEnc(37, 5, 6, 8, 0), 32'h3C008F0D, 5'd8, 0, "R3 or");
    exec(1, rEnc(39, 5, 0, 9, 0), 32'hC3FF7FFE, 5'd9, 0, "R3 nor");
    exec(1, rEnc(42, 2, 1, 10, 0), 32'd1, 5'd10, 0, "R4 slt signed true");
    exec(1, rEnc(42, 1, 2, 11, 0), 32'd0, 5'd11, 0, "R4 slt signed false");
    exec(1, iEnc(10, 1, 12, 6), 32'd1, 5'd12, 0, "R4 slti true");
    exec(1, iEnc(10, 1, 13, 16'hFFFF), 32'd0, 5'd13, 0, "R4 slti negative imm");
    exec(1, rEnc(0, 0, 1, 14, 4), 32'h50, 5'd14, 0, "R5 sll by 4");
    exec(1, rEnc(0, 0, 2, 15, 31), 32'h80000000, 5'd15, 0, "R5 sll by 31");

    // R9: write to register 0 is dropped
    exec(1, iEnc(8, 1, 0, 7), 32'd12, 5'd0, 0, "R9 addi to r0");
    exec(1, rEnc(37, 0, 0, 16, 0), 32'd0, 5'd16, 0, "R9 r0 reads zero");
    exec(1, rEnc(32, 0, 1, 17, 0), 32'd5, 5'd17, 0, "R9 r0 plus r1");

    // R10: illegal opcode and illegal function, no write-back
    exec(1, iEnc(63, 0, 1, 16'h1234), 32'd0, 5'd0, 1, "R10 bad opcode");
    exec(1, rEnc(63, 1, 1, 1, 0), 32'd0, 5'd0, 1, "R10 bad function");
    exec(1, rEnc(37, 1, 0, 18, 0), 32'd5, 5'd18, 0, "R10 r1 unchanged");

    // R11: not valid, nothing written
    exec(0, iEnc(8, 0, 1, 99), 32'd0, 5'd0, 0, "R11 idle outputs");
    exec(1, rEnc(37, 1, 0, 19, 0), 32'd5, 5'd19, 0, "R11 r1 unchanged");

    // R12: dependent back-to-back instructions
    exec(1, rEnc(32, 1, 1, 1, 0), 32'd10, 5'd1, 0, "R12 add self");
    exec(1, rEnc(32, 1, 1, 1, 0), 32'd20, 5'd1, 0, "R12 next sees new value");
    exec(1, rEnc(37, 1, 0, 20, 0), 32'd20, 5'd20, 0, "R12 readback");

    @(negedge clk);
    instValid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule